// File: doc/BRIEF.md
# Dual-Channel Direct Digital Synthesis Core

This block holds two tone generators that share one system clock. Each generator keeps a running phase by adding its tuning word to an accumulator on every clock. It shifts that phase by a per-channel offset and turns the result into a cosine value through a quarter-wave table. It then scales the value by a per-channel gain and emits one unsigned 10-bit sample per clock for an external converter.

Control words arrive on plain "pending" inputs. These come from a register port that sits outside this block. The pending words are not used until an update strobe is seen. The strobe is honoured only on the sync strobe, which fires on one system clock in every four, so a change lands on a known clock. Tuning, offset and gain changes travel through delay lines of equal length, so one combined update reaches the output on a single sample. A channel can also sweep: at a fixed interval it adds a step to its tuning word, stopping at an end value.

The sample outputs have no valid or ready. The converter takes a sample on every clock and cannot stall, so back-pressure has no meaning here and a fresh sample is always present.

Top module: `dds_dual_core`

## Requirements
- R1: Synchronous reset clears the accumulators and the tuning, offset and sweep words, and sets each gain word to 1023. While reset is high every sample output reads 512. With no update after reset, each output settles to 1022 (phase 0, full gain).
- R2: On every clock each channel adds its 32-bit tuning word to its 32-bit accumulator, modulo 2^32. The top 15 accumulator bits form the phase.
- R3: The 14-bit offset word is added, modulo 2^15, to the 15-bit phase with its LSB aligned to phase bit 1 (offset x2).
- R4: For phase p, the quadrant is p[14:13] and the index is i = p[12:5]; i is mirrored to 255-i in quadrants 1 and 3. Magnitude = round(511*cos(pi*(i+0.5)/512)), negated in quadrants 1 and 2.
- R5: The sample is 512 + floor(s*A/1024), where s is the signed cosine value and A is the 10-bit gain. Gain 0 gives 512, and no sample is ever 0.
- R6: Words applied at edge E feed the accumulator from edge E+1. Tuning, offset and gain all first show up together in the sample registered at edge E+4.
- R7: sync_strobe is high on one clock in four, starting with the fourth clock after reset. An update strobe seen on a sync_strobe clock applies at that edge. A strobe seen at any other time is held and applied at the next sync_strobe edge.
- R8: The two channels run from independent words and do not affect each other.
- R9: With sweep on, the tuning word gains the 32-bit step once every (rate+1) sync_strobe edges, counted from the update that armed the sweep.
- R10: A sweep step that would reach or pass the end word sets the tuning word to the end word. It stays there until the next update.
- R11: Changes on the pending inputs without an update strobe have no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| upd_req | input | 1 | Update strobe: move pending words to active |
| pend_ftw | input | 64 | Pending tuning words, channel c at [32c+:32] |
| pend_pow | input | 28 | Pending phase offsets, channel c at [14c+:14] |
| pend_amp | input | 20 | Pending gain words, channel c at [10c+:10] |
| pend_swp | input | 2 | Pending sweep enable, one bit per channel |
| pend_dftw | input | 64 | Pending sweep step words |
| pend_fend | input | 64 | Pending sweep end tuning words |
| pend_rate | input | 16 | Pending sweep interval counts, in sync strobes |
| sync_strobe | output | 1 | High on the clock at which updates and sweep steps occur |
| dac_data | output | 20 | Offset-binary samples, channel c at [10c+:10] |

## Verification
The bench builds the core with its defaults: two channels, 32-bit tuning, a 256-entry quarter table and a divide-by-four sync strobe. A quarter-turn tuning word then walks every quadrant and both mirror directions within four clocks. With an 8-bit interval, rates of 0 and 2 drive a sweep into its end clamp within a few dozen clocks. A reference model checks every sample of both channels against the arithmetic in the requirements, so a combined update exposes any skew between the three delay lines.

// File: rtl/dds_pkg.sv
package dds_pkg;

  localparam int DDS_FTW_W = 32;
  localparam int DDS_POW_W = 14;
  localparam int DDS_AMP_W = 10;
  localparam int DDS_OUT_W = 10;

  // Quarter-wave entry sampled at the middle of each index slot, so the
  // four quadrants mirror exactly without a shared end point.
  function automatic int cos_mag(int idx, int tab_bits, int peak);
    real ang;
    ang = 3.14159265358979 * (real'(idx) + 0.5) / (2.0 * real'(1 << tab_bits));
    return $rtoi(real'(peak) * $cos(ang) + 0.5);
  endfunction

endpackage

// File: rtl/dds_sync_ctrl.sv
module dds_sync_ctrl #(
  parameter int SYNC_DIV = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic upd_i,
  output logic tick_o,
  output logic apply_o
);
  localparam int CNT_W = (SYNC_DIV > 2) ? $clog2(SYNC_DIV) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SYNC_DIV - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             pend_q;

  assign tick_o  = (cnt_q == LAST);
  assign apply_o = tick_o && (upd_i || pend_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      cnt_q  <= tick_o ? '0 : cnt_q + 1'b1;
      pend_q <= !apply_o && (pend_q || upd_i);
    end
  end

  AST_PEND_DRAINS: assert property (@(posedge clk) disable iff (rst)
    (pend_q && tick_o) |=> !pend_q); // R7
  AST_TICK_SPACING: assert property (@(posedge clk) disable iff (rst)
    tick_o |=> !tick_o); // R7

endmodule

// File: rtl/dds_word_bank.sv
module dds_word_bank #(
  parameter int FTW_W  = 32,
  parameter int POW_W  = 14,
  parameter int AMP_W  = 10,
  parameter int RATE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              apply_i,
  input  logic              tick_i,
  input  logic [FTW_W-1:0]  ld_ftw_i,
  input  logic [POW_W-1:0]  ld_pow_i,
  input  logic [AMP_W-1:0]  ld_amp_i,
  input  logic              ld_swp_i,
  input  logic [FTW_W-1:0]  ld_dftw_i,
  input  logic [FTW_W-1:0]  ld_fend_i,
  input  logic [RATE_W-1:0] ld_rate_i,
  output logic [FTW_W-1:0]  ftw_o,
  output logic [POW_W-1:0]  pow_o,
  output logic [AMP_W-1:0]  amp_o
);
  logic [FTW_W-1:0]  ftw_q, dftw_q, fend_q;
  logic [POW_W-1:0]  pow_q;
  logic [AMP_W-1:0]  amp_q;
  logic              swp_q;
  logic [RATE_W-1:0] rate_q, rcnt_q;

  logic [FTW_W:0]    sum;
  logic [FTW_W-1:0]  swp_nxt;
  logic              step;

  // Wide sum keeps the carry so a step past 2^32 still clamps.
  assign sum     = {1'b0, ftw_q} + {1'b0, dftw_q};
  assign swp_nxt = (sum >= {1'b0, fend_q}) ? fend_q : sum[FTW_W-1:0];
  assign step    = tick_i && !apply_i && swp_q && (rcnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      ftw_q  <= '0;
      pow_q  <= '0;
      amp_q  <= '1;
      swp_q  <= 1'b0;
      dftw_q <= '0;
      fend_q <= '0;
      rate_q <= '0;
      rcnt_q <= '0;
    end else if (apply_i) begin
      ftw_q  <= ld_ftw_i;
      pow_q  <= ld_pow_i;
      amp_q  <= ld_amp_i;
      swp_q  <= ld_swp_i;
      dftw_q <= ld_dftw_i;
      fend_q <= ld_fend_i;
      rate_q <= ld_rate_i;
      rcnt_q <= ld_rate_i;
    end else if (tick_i && swp_q) begin
      if (rcnt_q == '0) begin
        ftw_q  <= swp_nxt;
        rcnt_q <= rate_q;
      end else begin
        rcnt_q <= rcnt_q - 1'b1;
      end
    end
  end

  assign ftw_o = ftw_q;
  assign pow_o = pow_q;
  assign amp_o = amp_q;

  AST_OFFSET_GAIN_HELD: assert property (@(posedge clk) disable iff (rst)
    !apply_i |=> ($stable(pow_q) && $stable(amp_q))); // R11
  AST_TUNING_HELD: assert property (@(posedge clk) disable iff (rst)
    (!apply_i && !step) |=> $stable(ftw_q)); // R9
  AST_SWEEP_CAPPED: assert property (@(posedge clk) disable iff (rst)
    step |=> (ftw_q <= fend_q)); // R10

endmodule

// File: rtl/dds_cos_lut.sv
module dds_cos_lut #(
  parameter int PH_W     = 15,
  parameter int TAB_BITS = 8,
  parameter int OUT_W    = 10
) (
  input  logic [PH_W-1:0]         ph_i,
  output logic signed [OUT_W-1:0] val_o
);
  localparam int MAG_W = OUT_W - 1;
  localparam int TAB_N = 1 << TAB_BITS;
  localparam int PEAK  = (1 << MAG_W) - 1;

  logic [MAG_W-1:0]    qtab [TAB_N];
  logic [1:0]          quad;
  logic [TAB_BITS-1:0] idx, sel;
  logic [MAG_W-1:0]    mag;

  for (genvar i = 0; i < TAB_N; i++) begin : g_tab
    assign qtab[i] = MAG_W'(dds_pkg::cos_mag(i, TAB_BITS, PEAK));
  end

  if (PH_W - 2 > TAB_BITS) begin : g_drop
    logic unused_ph_lsb;
    assign unused_ph_lsb = ^ph_i[PH_W-3-TAB_BITS:0];
  end

  assign quad  = ph_i[PH_W-1 -: 2];
  assign idx   = ph_i[PH_W-3 -: TAB_BITS];
  assign sel   = quad[0] ? ~idx : idx;
  assign mag   = qtab[sel];
  assign val_o = (quad[1] ^ quad[0]) ? -$signed({1'b0, mag}) : $signed({1'b0, mag});

endmodule

// File: rtl/dds_channel.sv
module dds_channel #(
  parameter int FTW_W    = 32,
  parameter int POW_W    = 14,
  parameter int PH_W     = 15,
  parameter int AMP_W    = 10,
  parameter int OUT_W    = 10,
  parameter int TAB_BITS = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [FTW_W-1:0] ftw_i,
  input  logic [POW_W-1:0] pow_i,
  input  logic [AMP_W-1:0] amp_i,
  output logic [OUT_W-1:0] dac_o
);
  localparam int PROD_W = OUT_W + AMP_W + 1;
  localparam logic [OUT_W-1:0] MID = OUT_W'(1 << (OUT_W - 1));

  logic [FTW_W-1:0]         acc_q;
  logic [POW_W-1:0]         pow_d1;
  logic [AMP_W-1:0]         amp_d1, amp_d2, amp_d3;
  logic [PH_W-1:0]          ph_q;
  logic signed [OUT_W-1:0]  smp_q, lut_val;
  logic [OUT_W-1:0]         dac_q, dac_n;
  logic signed [PROD_W-1:0] prod, shifted;

  dds_cos_lut #(.PH_W(PH_W), .TAB_BITS(TAB_BITS), .OUT_W(OUT_W)) u_lut (
    .ph_i (ph_q),
    .val_o(lut_val)
  );

  assign prod    = $signed(smp_q) * $signed({1'b0, amp_d3});
  assign shifted = prod >>> AMP_W;
  assign dac_n   = shifted[OUT_W-1:0] + MID;

  // Offset and gain ride one extra stage each so they meet the first
  // accumulator value built from a tuning word loaded on the same edge.
  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q  <= '0;
      pow_d1 <= '0;
      amp_d1 <= '0;
      amp_d2 <= '0;
      amp_d3 <= '0;
      ph_q   <= '0;
      smp_q  <= '0;
      dac_q  <= MID;
    end else begin
      acc_q  <= acc_q + ftw_i;
      pow_d1 <= pow_i;
      amp_d1 <= amp_i;
      ph_q   <= acc_q[FTW_W-1 -: PH_W] + (PH_W'(pow_d1) << (PH_W - POW_W));
      amp_d2 <= amp_d1;
      smp_q  <= lut_val;
      amp_d3 <= amp_d2;
      dac_q  <= dac_n;
    end
  end

  assign dac_o = dac_q;

  AST_NEVER_ZERO: assert property (@(posedge clk) disable iff (rst)
    dac_q != '0); // R5
  AST_ZERO_GAIN_MID: assert property (@(posedge clk) disable iff (rst)
    (amp_d3 == '0) |=> (dac_q == MID)); // R5

endmodule

// File: rtl/dds_dual_core.sv
module dds_dual_core #(
  parameter int NCH      = 2,
  parameter int FTW_W    = dds_pkg::DDS_FTW_W,
  parameter int POW_W    = dds_pkg::DDS_POW_W,
  parameter int PH_W     = 15,
  parameter int AMP_W    = dds_pkg::DDS_AMP_W,
  parameter int OUT_W    = dds_pkg::DDS_OUT_W,
  parameter int TAB_BITS = 8,
  parameter int RATE_W   = 8,
  parameter int SYNC_DIV = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    upd_req,
  input  logic [NCH*FTW_W-1:0]    pend_ftw,
  input  logic [NCH*POW_W-1:0]    pend_pow,
  input  logic [NCH*AMP_W-1:0]    pend_amp,
  input  logic [NCH-1:0]          pend_swp,
  input  logic [NCH*FTW_W-1:0]    pend_dftw,
  input  logic [NCH*FTW_W-1:0]    pend_fend,
  input  logic [NCH*RATE_W-1:0]   pend_rate,
  output logic                    sync_strobe,
  output logic [NCH*OUT_W-1:0]    dac_data
);
  logic tick, apply;

  dds_sync_ctrl #(.SYNC_DIV(SYNC_DIV)) u_sync (
    .clk    (clk),
    .rst    (rst),
    .upd_i  (upd_req),
    .tick_o (tick),
    .apply_o(apply)
  );

  assign sync_strobe = tick;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [FTW_W-1:0] ftw_a;
    logic [POW_W-1:0] pow_a;
    logic [AMP_W-1:0] amp_a;

    dds_word_bank #(.FTW_W(FTW_W), .POW_W(POW_W), .AMP_W(AMP_W), .RATE_W(RATE_W)) u_bank (
      .clk      (clk),
      .rst      (rst),
      .apply_i  (apply),
      .tick_i   (tick),
      .ld_ftw_i (pend_ftw[c*FTW_W +: FTW_W]),
      .ld_pow_i (pend_pow[c*POW_W +: POW_W]),
      .ld_amp_i (pend_amp[c*AMP_W +: AMP_W]),
      .ld_swp_i (pend_swp[c]),
      .ld_dftw_i(pend_dftw[c*FTW_W +: FTW_W]),
      .ld_fend_i(pend_fend[c*FTW_W +: FTW_W]),
      .ld_rate_i(pend_rate[c*RATE_W +: RATE_W]),
      .ftw_o    (ftw_a),
      .pow_o    (pow_a),
      .amp_o    (amp_a)
    );

    dds_channel #(.FTW_W(FTW_W), .POW_W(POW_W), .PH_W(PH_W), .AMP_W(AMP_W),
                  .OUT_W(OUT_W), .TAB_BITS(TAB_BITS)) u_chan (
      .clk  (clk),
      .rst  (rst),
      .ftw_i(ftw_a),
      .pow_i(pow_a),
      .amp_i(amp_a),
      .dac_o(dac_data[c*OUT_W +: OUT_W])
    );
  end

endmodule

// File: tb/dds_dual_core_bench.sv
module dds_dual_core_bench;
  localparam int NC = 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          upd_req = 1'b0;
  logic [63:0]   pend_ftw = '0;
  logic [27:0]   pend_pow = '0;
  logic [19:0]   pend_amp = '1;
  logic [1:0]    pend_swp = '0;
  logic [63:0]   pend_dftw = '0;
  logic [63:0]   pend_fend = '0;
  logic [15:0]   pend_rate = '0;
  logic          sync_strobe;
  logic [19:0]   dac_data;

  int checks = 0;
  int errors = 0;
  string cur_tag = "R1";

  always #5 clk = ~clk;

  dds_dual_core u_dds_dual_core (
    .clk(clk), .rst(rst), .upd_req(upd_req),
    .pend_ftw(pend_ftw), .pend_pow(pend_pow), .pend_amp(pend_amp),
    .pend_swp(pend_swp), .pend_dftw(pend_dftw), .pend_fend(pend_fend),
    .pend_rate(pend_rate), .sync_strobe(sync_strobe), .dac_data(dac_data)
  );

  typedef struct { int e0; int e1; string tag; } exp_t;
  exp_t sb[$];

  function automatic int cos_ref(int p);
    int q, i, m;
    q = (p >> 13) & 3;
    i = (p >> 5) & 255;
    if (q == 1 || q == 3) i = 255 - i;
    m = $rtoi(511.0 * $cos(3.14159265358979 * (real'(i) + 0.5) / 512.0) + 0.5);
    return (q == 1 || q == 2) ? -m : m;
  endfunction

  task automatic check(string tag, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got %0d expected %0d", tag, got, exp);
    end
  endtask

  // Reference model built from the requirements; pushes one expected item per edge.
  logic [31:0] m_ftw[NC], m_dftw[NC], m_fend[NC], m_acc[NC];
  int m_pow[NC], m_pow1[NC], m_amp[NC], m_amp1[NC], m_amp2[NC], m_amp3[NC];
  int m_ph2[NC], m_s3[NC], m_out[NC], m_rate[NC], m_rcnt[NC];
  bit m_swp[NC];
  int m_cnt;
  bit m_pend;

  always @(posedge clk) begin : model
    bit tick, ap;
    logic [32:0] sum;
    exp_t it;
    if (rst) begin
      m_cnt = 0; m_pend = 0;
      for (int c = 0; c < NC; c++) begin
        m_ftw[c] = 0; m_dftw[c] = 0; m_fend[c] = 0; m_acc[c] = 0;
        m_pow[c] = 0; m_pow1[c] = 0; m_amp[c] = 1023; m_amp1[c] = 0;
        m_amp2[c] = 0; m_amp3[c] = 0; m_ph2[c] = 0; m_s3[c] = 0;
        m_out[c] = 512; m_rate[c] = 0; m_rcnt[c] = 0; m_swp[c] = 0;
      end
    end else begin
      tick = (m_cnt == 3);
      ap = tick && (upd_req || m_pend);
      for (int c = 0; c < NC; c++) begin
        m_out[c]  = 512 + ((m_s3[c] * m_amp3[c]) >>> 10);
        m_s3[c]   = cos_ref(m_ph2[c]);
        m_amp3[c] = m_amp2[c];
        m_ph2[c]  = (int'(m_acc[c][31:17]) + 2 * m_pow1[c]) & 32'h7fff;
        m_amp2[c] = m_amp1[c];
        m_pow1[c] = m_pow[c];
        m_amp1[c] = m_amp[c];
        m_acc[c]  = m_acc[c] + m_ftw[c];
        if (ap) begin
          m_ftw[c]  = pend_ftw[c*32 +: 32];
          m_pow[c]  = int'(pend_pow[c*14 +: 14]);
          m_amp[c]  = int'(pend_amp[c*10 +: 10]);
          m_swp[c]  = pend_swp[c];
          m_dftw[c] = pend_dftw[c*32 +: 32];
          m_fend[c] = pend_fend[c*32 +: 32];
          m_rate[c] = int'(pend_rate[c*8 +: 8]);
          m_rcnt[c] = m_rate[c];
        end else if (tick && m_swp[c]) begin
          if (m_rcnt[c] == 0) begin
            sum = {1'b0, m_ftw[c]} + {1'b0, m_dftw[c]};
            m_ftw[c] = (sum >= {1'b0, m_fend[c]}) ? m_fend[c] : sum[31:0];
            m_rcnt[c] = m_rate[c];
          end else begin
            m_rcnt[c] = m_rcnt[c] - 1;
          end
        end
      end
      m_pend = ap ? 1'b0 : (m_pend || upd_req);
      m_cnt = (m_cnt + 1) % 4;
    end
    it.e0 = m_out[0]; it.e1 = m_out[1]; it.tag = cur_tag;
    sb.push_back(it);
  end

  // Monitor: compares each registered sample half a cycle after it appears.
  always @(negedge clk) begin
    exp_t it;
    if (sb.size() > 0) begin
      it = sb.pop_front();
      check({it.tag, " ch0"}, int'(dac_data[9:0]), it.e0);
      check({it.tag, " ch1"}, int'(dac_data[19:10]), it.e1);
    end
  end

  task automatic set_words(int c, logic [31:0] f, logic [13:0] p, logic [9:0] a);
    pend_ftw[c*32 +: 32] = f;
    pend_pow[c*14 +: 14] = p;
    pend_amp[c*10 +: 10] = a;
  endtask

  task automatic set_sweep(int c, bit en, logic [31:0] d, logic [31:0] e, logic [7:0] r);
    pend_swp[c] = en;
    pend_dftw[c*32 +: 32] = d;
    pend_fend[c*32 +: 32] = e;
    pend_rate[c*8 +: 8] = r;
  endtask

  task automatic pulse_upd();
    @(negedge clk) upd_req = 1'b1;
    @(negedge clk) upd_req = 1'b0;
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin : driver
    int ticks;
    repeat (6) @(negedge clk);
    check("R1 reset ch0", int'(dac_data[9:0]), 512);
    check("R1 reset ch1", int'(dac_data[19:10]), 512);
    rst = 1'b0;
    cur_tag = "R1 settle";
    repeat (20) @(negedge clk);
    check("R1 idle ch0", int'(dac_data[9:0]), 1022);
    check("R1 idle ch1", int'(dac_data[19:10]), 1022);

    ticks = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (sync_strobe) ticks++;
    end
    check("R7 strobe count", ticks, 10);

    cur_tag = "R2 R4 R8";
    set_words(0, 32'h0123_4567, 14'h0, 10'd1023);
    set_words(1, 32'h4000_0000, 14'h0, 10'd1023);
    pulse_upd();
    repeat (60) @(negedge clk);

    cur_tag = "R3";
    set_words(0, 32'h0123_4567, 14'h1000, 10'd1023);
    set_words(1, 32'h4000_0000, 14'h2abc, 10'd1023);
    pulse_upd();
    repeat (40) @(negedge clk);

    cur_tag = "R5";
    set_words(0, 32'h0123_4567, 14'h1000, 10'd0);
    set_words(1, 32'h0234_5678, 14'h0, 10'd300);
    pulse_upd();
    repeat (20) @(negedge clk);
    check("R5 zero gain mid", int'(dac_data[9:0]), 512);
    set_words(0, 32'h0300_0000, 14'h0, 10'd1023);
    set_words(1, 32'h0234_5678, 14'h0, 10'd1);
    pulse_upd();
    repeat (30) @(negedge clk);

    cur_tag = "R11";
    set_words(0, 32'h7777_0000, 14'h3fff, 10'd5);
    set_words(1, 32'h1111_1111, 14'h0123, 10'd700);
    repeat (40) @(negedge clk);

    cur_tag = "R7 held";
    while (!sync_strobe) @(negedge clk);
    @(negedge clk);
    upd_req = 1'b1;
    @(negedge clk) upd_req = 1'b0;
    repeat (20) @(negedge clk);
    cur_tag = "R7 on strobe";
    set_words(0, 32'h0400_0000, 14'h0800, 10'd600);
    while (!sync_strobe) @(negedge clk);
    upd_req = 1'b1;
    @(negedge clk) upd_req = 1'b0;
    repeat (20) @(negedge clk);

    cur_tag = "R6 prep";
    set_words(0, 32'h0, 14'h0, 10'd0);
    pulse_upd();
    repeat (20) @(negedge clk);
    cur_tag = "R6";
    set_words(0, 32'h0800_0000, 14'h2000, 10'd1023);
    pulse_upd();
    repeat (30) @(negedge clk);

    cur_tag = "R9 R10";
    set_words(0, 32'h0, 14'h0, 10'd1023);
    set_sweep(0, 1'b1, 32'h0100_0000, 32'h0500_0000, 8'd2);
    set_words(1, 32'h3000_0000, 14'h0, 10'd1023);
    set_sweep(1, 1'b1, 32'h0000_0010, 32'h1000_0000, 8'd0);
    pulse_upd();
    repeat (150) @(negedge clk);

    cur_tag = "R10 release";
    set_words(0, 32'h0200_0000, 14'h0, 10'd800);
    set_sweep(0, 1'b0, 32'h0, 32'h0, 8'd0);
    pulse_upd();
    repeat (40) @(negedge clk);

    finish_run();
  end

endmodule